// File: doc/BRIEF.md
# Shared-Ratio Reference Input Divider

This block brings several reference inputs down to a common comparison rate, nominally 8 kHz, before they reach a phase detector. Every input is presented as a one-cycle edge strobe in the system clock domain, and every channel returns a one-cycle divided strobe in the same domain. Each channel has its own configuration byte, which selects one of three modes:

- pass the strobe straight through;
- halve it, for a direct-lock high-rate input that must stay under the comparison limit;
- divide it by the shared ratio N+1.

Only one N exists for the whole block, so every dividing channel must carry the same input frequency. N is loaded through a small synchronous byte-wide write port. The low byte is staged first, and the value only takes effect when the high byte is written. When the assembled N falls outside 1..12499, a status output flags it and the dividing channels stay silent.

Top module: `shared_ratio_divider`

## Requirements
- R1: After synchronous reset, every channel is in pass-through mode, N is 0, `ratio_bad` is 1 and `div_strobe` is all zero.
- R2: In pass-through mode (configuration bit 7 = 0 and bit 6 = 0), `div_strobe[i]` equals `ref_strobe[i]` delayed by one clock.
- R3: In halving mode (bit 7 = 0 and bit 6 = 1), a channel emits a strobe one clock after every second input strobe. Counting starts from the first strobe after reset, after a ratio commit or after a write to that channel's configuration.
- R4: In divide mode (bit 7 = 1), with a legal N, a channel emits one strobe one clock after every (N+1)-th input strobe, giving exactly one output per N+1 inputs.
- R5: Configuration bits 5:0 have no effect, and bit 6 has no effect while bit 7 is set.
- R6: A write to address 0x20 only stages the low 8 bits of N. A write to address 0x21 commits N = {data[5:0], staged low byte}. Data bits 7:6 of the high write are ignored.
- R7: If the committed N is 0 or greater than 12499, `ratio_bad` is 1 from the clock after the high write, and divide-mode channels emit nothing and hold their count at zero. A legal N clears `ratio_bad` in the same way.
- R8: A ratio commit clears the count of every halving and dividing channel. A strobe arriving in the commit cycle on such a channel is discarded.
- R9: A write to a channel's configuration address (0x00 + channel index) clears that channel's count and suppresses its output for that cycle. The new mode applies from the next cycle.
- R10: Channels count independently. A strobe on one channel never advances or triggers another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | NUM_CH | One-cycle edge strobes, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data byte |
| div_strobe | output | NUM_CH | Registered divided strobes, one bit per channel |
| ratio_bad | output | 1 | Committed N is outside the legal range |

## Verification
Two events can fall in the same cycle and are the interesting collisions:

- a ratio commit or a channel configuration write;
- an input strobe that would complete a count.

The bench provokes both by issuing every commit and configuration write with all input strobes high while counts are part-way or exactly at N. It judges the result by expecting the clear to win: no output in the following cycle, and the count restarting so that the next output comes N+1 strobes later. Ratios 1 to 16 are swept against dense pseudo-random strobe patterns. The top legal ratio and the first illegal one are exercised as well.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HALF = 2'd1,
    MODE_DIV  = 2'd2
  } chan_mode_e;

  localparam int CFG_DIV_BIT  = 7;
  localparam int CFG_HALF_BIT = 6;

  // Only the two top bits of a configuration byte select behaviour.
  function automatic chan_mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return MODE_DIV;
    else if (sel[0]) return MODE_HALF;
    else             return MODE_PASS;
  endfunction

endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
  import refdiv_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 8,
  parameter int N_W     = 14,
  parameter int N_MAX   = 12499,
  parameter int LO_ADDR = 32,
  parameter int HI_ADDR = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output chan_mode_e        mode_o [NUM_CH],
  output logic [N_W-1:0]    ratio_n,
  output logic              ratio_bad,
  output logic              ratio_commit,
  output logic [NUM_CH-1:0] cfg_wr
);

  localparam int HI_W = N_W - 8;

  logic [7:0]     lo_stage;
  logic [N_W-1:0] next_n;
  logic           lo_wr;

  assign lo_wr        = wr_en && (wr_addr == ADDR_W'(LO_ADDR));
  assign ratio_commit = wr_en && (wr_addr == ADDR_W'(HI_ADDR));
  assign next_n       = {wr_data[HI_W-1:0], lo_stage};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage  <= '0;
      ratio_n   <= '0;
      ratio_bad <= 1'b1;
    end else begin
      if (lo_wr) lo_stage <= wr_data;
      if (ratio_commit) begin
        ratio_n   <= next_n;
        ratio_bad <= (next_n == '0) || (next_n > N_W'(N_MAX));
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
    assign cfg_wr[i] = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)            mode_o[i] <= MODE_PASS;
      else if (cfg_wr[i]) mode_o[i] <= decode_mode(wr_data[CFG_DIV_BIT:CFG_HALF_BIT]);
    end
  end

  // R6: staging the low byte never moves the active ratio
  p_lo_staged_only_r6: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !ratio_commit) |=> $stable(ratio_n));

  // R7: status flag agrees with the ratio it describes
  p_bad_matches_range_r7: assert property (@(posedge clk) disable iff (rst)
    ratio_bad == ((ratio_n == '0) || (ratio_n > N_W'(N_MAX))));

  // R1: reset leaves the ratio flagged illegal
  p_reset_bad_r1: assert property (@(posedge clk)
    $past(rst) |-> (ratio_bad && ratio_n == '0));

endmodule

// File: rtl/refdiv_chan.sv
module refdiv_chan
  import refdiv_pkg::*;
#(
  parameter int N_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  chan_mode_e     mode,
  input  logic [N_W-1:0] ratio_n,
  input  logic           ratio_bad,
  input  logic           ratio_commit,
  input  logic           cfg_clear,
  output logic           out
);

  logic [N_W-1:0] cnt;
  logic           clr;
  logic           wrap;

  assign clr  = cfg_clear || (ratio_commit && mode != MODE_PASS);
  assign wrap = (cnt == ratio_n);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      out <= 1'b0;
    end else begin
      unique case (mode)
        MODE_HALF: begin
          out <= strobe && cnt[0];
          cnt <= {{(N_W-1){1'b0}}, cnt[0] ^ strobe};
        end
        MODE_DIV: begin
          if (ratio_bad) begin
            cnt <= '0;
            out <= 1'b0;
          end else if (strobe) begin
            out <= wrap;
            cnt <= wrap ? '0 : cnt + N_W'(1);
          end else begin
            out <= 1'b0;
          end
        end
        default: begin
          out <= strobe;
          cnt <= '0;
        end
      endcase
    end
  end

  // R4: count never runs past the shared ratio
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DIV && !ratio_bad) |-> (cnt <= ratio_n));

  // R7: an illegal ratio silences a dividing channel
  p_bad_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DIV && ratio_bad) |=> (!out && cnt == '0));

  // R8: commit clears a counting channel and drops the colliding strobe
  p_commit_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (ratio_commit && mode != MODE_PASS) |=> (!out && cnt == '0));

  // R9: configuration write suppresses the channel for that cycle
  p_cfg_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |=> !out);

  // R2: pass-through is a one-cycle delay
  p_pass_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PASS && !cfg_clear) |=> (out == $past(strobe)));

  // R3: halving phase stays a single bit
  p_half_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALF) |-> (cnt <= N_W'(1)));

endmodule

// File: rtl/shared_ratio_divider.sv
module shared_ratio_divider
  import refdiv_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 8,
  parameter int N_W     = 14,
  parameter int N_MAX   = 12499,
  parameter int LO_ADDR = 32,
  parameter int HI_ADDR = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ref_strobe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] div_strobe,
  output logic              ratio_bad
);

  chan_mode_e        ch_mode [NUM_CH];
  logic [N_W-1:0]    ratio_n;
  logic              ratio_commit;
  logic [NUM_CH-1:0] cfg_wr;

  refdiv_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .N_W    (N_W),
    .N_MAX  (N_MAX),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mode_o      (ch_mode),
    .ratio_n     (ratio_n),
    .ratio_bad   (ratio_bad),
    .ratio_commit(ratio_commit),
    .cfg_wr      (cfg_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    refdiv_chan #(
      .N_W(N_W)
    ) u_chan (
      .clk         (clk),
      .rst         (rst),
      .strobe      (ref_strobe[i]),
      .mode        (ch_mode[i]),
      .ratio_n     (ratio_n),
      .ratio_bad   (ratio_bad),
      .ratio_commit(ratio_commit),
      .cfg_clear   (cfg_wr[i]),
      .out         (div_strobe[i])
    );
  end

  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (div_strobe == '0));

endmodule

// File: tb/shared_ratio_divider_tb.sv
`timescale 1ns/1ps
module shared_ratio_divider_tb;

  localparam int NCH   = 4;
  localparam int N_MAX = 12499;
  localparam logic [7:0] A_LO = 8'h20;
  localparam logic [7:0] A_HI = 8'h21;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst;
  logic [NCH-1:0] ref_strobe;
  logic           wr_en;
  logic [7:0]     wr_addr, wr_data;
  logic [NCH-1:0] div_strobe;
  logic           ratio_bad;

  shared_ratio_divider u_dut (
    .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .div_strobe(div_strobe),
    .ratio_bad(ratio_bad)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Requirement-level model: mode 0 pass, 1 halve, 2 divide
  int         m_mode [NCH];
  int         m_cnt  [NCH];
  int         m_n;
  logic [7:0] m_lo;
  bit         m_bad;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [NCH-1:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[NCH-1:0] | lf[NCH+3:4];
  endfunction

  task automatic check_bit(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check the registered result one edge later.
  task automatic step(input logic [NCH-1:0] stb, input bit we,
                      input logic [7:0] a, input logic [7:0] d, input string tag);
    logic [NCH-1:0] e;
    bit commit;
    ref_strobe = stb; wr_en = we; wr_addr = a; wr_data = d;
    commit = we && (a == A_HI);
    for (int c = 0; c < NCH; c++) begin
      bit cw;
      cw = we && (a == 8'(c));
      e[c] = 1'b0;
      if (cw || (commit && m_mode[c] != 0)) begin
        m_cnt[c] = 0;
      end else if (m_mode[c] == 0) begin
        e[c] = stb[c];
      end else if (m_mode[c] == 1) begin
        if (stb[c]) begin
          e[c] = (m_cnt[c] == 1);
          m_cnt[c] = 1 - m_cnt[c];
        end
      end else begin
        if (m_bad) m_cnt[c] = 0;
        else if (stb[c]) begin
          if (m_cnt[c] == m_n) begin e[c] = 1'b1; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end
      end
    end
    if (we) begin
      if (a < 8'(NCH)) m_mode[a] = d[7] ? 2 : (d[6] ? 1 : 0);
      if (a == A_LO) m_lo = d;
      if (a == A_HI) begin
        m_n   = int'({d[5:0], m_lo});
        m_bad = (m_n == 0) || (m_n > N_MAX);
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check_bit(tag, "div_strobe", int'(div_strobe), int'(e));
    check_bit(tag, "ratio_bad", int'(ratio_bad), int'(m_bad));
  endtask

  task automatic run(int cycles, string tag);
    for (int k = 0; k < cycles; k++) step(rnd(), 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    step({NCH{1'b1}}, 1'b1, a, d, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; ref_strobe = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int c = 0; c < NCH; c++) begin m_mode[c] = 0; m_cnt[c] = 0; end
    m_n = 0; m_lo = 8'h00; m_bad = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_bit("R1", "div_strobe", int'(div_strobe), 0);
    check_bit("R1", "ratio_bad", int'(ratio_bad), 1);
    step(4'b1010, 1'b0, 8'h00, 8'h00, "R1");
    // R2: pass-through across patterns
    run(20, "R2");
    // R3: halving; R5: low bits ignored on channel 2
    wr(8'h01, 8'h40, "R9");
    wr(8'h02, 8'h7F, "R5");
    run(24, "R3");
    // R6: staging the low byte alone leaves N illegal
    wr(8'h00, 8'h80, "R9");
    wr(A_LO, 8'h03, "R6");
    run(10, "R6");
    wr(A_HI, 8'hC0, "R6");          // N = 3, bits 7:6 ignored
    run(30, "R4");
    // R5: bit 6 ignored while bit 7 set
    wr(8'h03, 8'hF5, "R5");
    run(30, "R5");
    // R4/R8: ratio sweep, each commit collides with strobes
    for (int n = 1; n <= 16; n++) begin
      wr(A_LO, 8'(n), "R8");
      wr(A_HI, 8'h00, "R8");
      run(3 * (n + 1) + 6, "R4");
    end
    // R10: independent channels with a mix of modes
    wr(8'h01, 8'h80, "R9");
    run(40, "R10");
    wr(8'h01, 8'h40, "R9");
    run(10, "R9");
    // R7: zero and just-over-limit ratios
    wr(A_LO, 8'h00, "R7");
    wr(A_HI, 8'h00, "R7");
    run(12, "R7");
    wr(A_LO, 8'hD4, "R7");
    wr(A_HI, 8'h30, "R7");          // 12500
    run(12, "R7");
    // R4: top legal ratio, continuous strobes on every channel
    wr(A_LO, 8'hD3, "R7");
    wr(A_HI, 8'h30, "R7");          // 12499
    for (int k = 0; k < 25010; k++) step({NCH{1'b1}}, 1'b0, 8'h00, 8'h00, "R4");
    finish_run();
  end

endmodule